// File: doc/BRIEF.md
# I2C Byte Shift Engine with Ninth-Clock Events

This block moves one byte at a time across an I2C bus under an externally paced SCL. Both bus lines first pass through a stability filter that accepts a new level only after it has held for a set number of system clocks. The engine then samples SDA on each accepted SCL rise, most significant bit first. It also drives its own transmit bits through an open-drain SDA enable. A ninth clock carries the acknowledge bit, whose level is recorded in a status bit.

Two mode inputs decide where the ninth clock's work happens. The event selector chooses between acknowledge-judged events (a NACK raises the transmit flag and an ACK raises the receive flag) and plain transmit/receive events. The clock-delay control chooses whether the block stretches SCL low between bytes and delays its SDA changes. It also decides whether the receive buffer is written once or twice. The double write uses a split layout first and the normal layout second. The bus is paced by the SCL of the far end, so no back-pressure is possible. For that reason every pin is a plain level or a single-cycle pulse rather than a valid/ready stream. The event flags stay set until a clear pulse arrives or a mode input changes.

Top module: `i2c_byte_shifter`

## Requirements
- R1: A level change on `scl_in` or `sda_in` is accepted only after it has held for `FILT_CYC` consecutive system clocks. A shorter pulse has no effect on the received byte or on the events.
- R2: `start_det` clears the bit counter. The first eight accepted SCL rises after it sample SDA into the shift register, MSB first. The ninth rise copies the SDA level into `ack_stat` (1 = not acknowledged). `ack_stat` changes at no other time.
- R3: With `evt_sel`=0, the ninth rise writes `rx_buf` = {ack level, byte}. At that rise, `tx_flag` sets if the ack level is 1, otherwise `rx_flag` sets. The two flags never set in the same cycle.
- R4: With `evt_sel`=1, the SCL fall that follows the eighth rise writes the split layout. In that layout `rx_buf[8]` = bit 8, `rx_buf[7]` = 0 and `rx_buf[6:0]` = bits 1..7. The same fall sets `rx_flag` and `rx_split`. A split write happens only with `evt_sel`=1.
- R5: With `evt_sel`=1 and `clk_dly`=0, `tx_flag` sets at the ninth rise, and `rx_buf` keeps the split layout.
- R6: With `evt_sel`=1 and `clk_dly`=1, the ninth rise rewrites `rx_buf` in the normal layout {ack level, byte} and clears `rx_split`. `tx_flag` sets at the SCL fall that ends the ninth bit.
- R7: `rx_data` returns the received byte in either layout. While `rx_split`=1 it is {`rx_buf[6:0]`, `rx_buf[8]`}, otherwise `rx_buf[7:0]`.
- R8: `tx_load` places bit 1 (MSB of `tx_byte`) on SDA. Each SCL fall ending bit k (k=1..8) moves to bit k+1. Bit 9 is the level ~`ack_low`. The fall ending bit 9 releases SDA. `sda_oe`=1 pulls SDA low, so it equals the inverse of the bit.
- R9: With `clk_dly`=1, every change of `sda_oe` happens exactly `TX_DLY` system clocks later than it would with `clk_dly`=0.
- R10: `scl_oe` is never 1 while `clk_dly`=0. With `clk_dly`=1 it is 1 from reset, and again from the fall ending bit 9, until the next `tx_load`.
- R11: After reset, and after a cycle in which `evt_sel` or `clk_dly` changed, both flags read 0. An `evt_clr` pulse also clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| start_det | input | 1 | Start-detected pulse, clears the bit counter |
| evt_sel | input | 1 | 0: acknowledge-judged events; 1: plain transmit/receive events |
| clk_dly | input | 1 | 1: SCL stretching and delayed SDA output |
| tx_load | input | 1 | Load pulse for `tx_byte` and `ack_low` |
| tx_byte | input | 8 | Byte to transmit, MSB first |
| ack_low | input | 1 | 1 drives SDA low during the ninth bit |
| evt_clr | input | 1 | Clears both event flags |
| scl_oe | output | 1 | Open-drain pull-low enable for SCL |
| sda_oe | output | 1 | Open-drain pull-low enable for SDA |
| rx_buf | output | 9 | Receive buffer, raw layout |
| rx_data | output | 8 | Receive byte, layout resolved |
| rx_split | output | 1 | Buffer currently holds the split layout |
| ack_stat | output | 1 | Ack level sampled at the ninth rise |
| tx_flag | output | 1 | Transmit-side event flag |
| rx_flag | output | 1 | Receive-side event flag |

## Verification
Several rules are checked on every cycle by the assertions. Both flags are zero after any mode change. The two flags never set together. `ack_stat` moves only on an accepted SCL rise. A split write happens only with the event selector high. `scl_oe` stays off while clock delay is off. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle at which each mode writes the buffer and raises each flag, the value written in each layout, the per-bit SDA sequence and its delay, and the rejection of short SCL glitches. The bench sweeps all four mode pairs over a set of corner bytes with both acknowledge levels.

// File: rtl/i2c_shf_pkg.sv
package i2c_shf_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic evt_sel;
    logic clk_dly;
  } mode_t;

  typedef enum logic [1:0] {
    LOAD_NONE   = 2'd0,
    LOAD_NORMAL = 2'd1,
    LOAD_SPLIT  = 2'd2
  } load_kind_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned STABLE_CYC = 25,
  parameter bit          RST_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int unsigned RUN_W = $clog2(STABLE_CYC + 1);

  logic [1:0]       sync_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_LVL}};
      clean  <= RST_LVL;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == clean) begin
        run_q <= '0;
      end else if (run_q == RUN_W'(STABLE_CYC - 1)) begin
        clean <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_shf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  mode_t            mode,
  input  logic             evt_clr,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [FRAME_W-1:0] rx_buf,
  output logic             rx_split,
  output logic             ack_stat,
  output logic             tx_flag,
  output logic             rx_flag
);
  logic [BYTE_W-1:0] shreg_q;
  mode_t             mode_q;
  logic              mode_chg;
  logic              rise9, fall8, fall9;
  logic              tx_set, rx_set;
  load_kind_e        load_kind;

  assign mode_chg = (mode != mode_q);
  assign rise9 = scl_rise && !start_det && (bit_cnt == CNT_W'(BYTE_W));
  assign fall8 = scl_fall && !start_det && (bit_cnt == CNT_W'(BYTE_W));
  assign fall9 = scl_fall && !start_det && (bit_cnt == CNT_W'(FRAME_W));

  always_comb begin
    load_kind = LOAD_NONE;
    tx_set    = 1'b0;
    rx_set    = 1'b0;
    if (!mode.evt_sel) begin
      if (rise9) begin
        load_kind = LOAD_NORMAL;
        tx_set    = sda_lvl;
        rx_set    = !sda_lvl;
      end
    end else begin
      if (fall8) begin
        load_kind = LOAD_SPLIT;
        rx_set    = 1'b1;
      end
      if (rise9 && mode.clk_dly) load_kind = LOAD_NORMAL;
      tx_set = mode.clk_dly ? fall9 : rise9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg_q  <= '0;
      ack_stat <= 1'b0;
    end else if (start_det) begin
      bit_cnt <= '0;
      shreg_q <= '0;
    end else if (scl_rise) begin
      if (bit_cnt < CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < CNT_W'(BYTE_W)) shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
      if (bit_cnt == CNT_W'(BYTE_W)) ack_stat <= sda_lvl;
    end else if (fall9) begin
      bit_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_split <= 1'b0;
    end else begin
      unique case (load_kind)
        LOAD_NORMAL: begin
          rx_buf   <= {sda_lvl, shreg_q};
          rx_split <= 1'b0;
        end
        LOAD_SPLIT: begin
          rx_buf   <= {shreg_q[0], 1'b0, shreg_q[BYTE_W-1:1]};
          rx_split <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg || evt_clr) begin
        tx_flag <= 1'b0;
        rx_flag <= 1'b0;
      end else begin
        tx_flag <= tx_flag | tx_set;
        rx_flag <= rx_flag | rx_set;
      end
    end
  end
endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
  import i2c_shf_pkg::*;
#(
  parameter int unsigned TX_DLY = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_low,
  input  logic              scl_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              clk_dly,
  output logic              sda_oe,
  output logic              scl_oe
);
  localparam int unsigned DLY_W = $clog2(TX_DLY + 1);

  logic [FRAME_W-1:0] word_q;
  logic [CNT_W-1:0]   idx_q;
  logic               active_q;
  logic               hold_q;
  logic               tgt;
  logic               sda_q;
  logic [DLY_W-1:0]   dcnt_q;

  assign tgt    = active_q ? word_q[CNT_W'(FRAME_W - 1) - idx_q] : 1'b1;
  assign sda_oe = !sda_q;
  assign scl_oe = clk_dly && hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '1;
      idx_q    <= '0;
      active_q <= 1'b0;
      hold_q   <= 1'b1;
    end else if (tx_load) begin
      word_q   <= {tx_byte, !ack_low};
      idx_q    <= '0;
      active_q <= 1'b1;
      hold_q   <= 1'b0;
    end else if (scl_fall) begin
      if (bit_cnt == CNT_W'(FRAME_W)) begin
        active_q <= 1'b0;
        hold_q   <= 1'b1;
      end else if (bit_cnt != '0) begin
        idx_q <= bit_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q  <= 1'b1;
      dcnt_q <= '0;
    end else if (tgt != sda_q) begin
      if (!clk_dly || dcnt_q == DLY_W'(TX_DLY)) begin
        sda_q  <= tgt;
        dcnt_q <= '0;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end else begin
      dcnt_q <= '0;
    end
  end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_shf_pkg::*;
#(
  parameter int unsigned FILT_CYC = 25,
  parameter int unsigned TX_DLY   = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       start_det,
  input  logic       evt_sel,
  input  logic       clk_dly,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  input  logic       ack_low,
  input  logic       evt_clr,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [8:0] rx_buf,
  output logic [7:0] rx_data,
  output logic       rx_split,
  output logic       ack_stat,
  output logic       tx_flag,
  output logic       rx_flag
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  logic              scl_d;
  logic              scl_rise, scl_fall;
  logic [CNT_W-1:0]  bit_cnt;
  mode_t             mode;

  assign raw_lines = {sda_in, scl_in};
  assign mode      = '{evt_sel: evt_sel, clk_dly: clk_dly};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.STABLE_CYC(FILT_CYC), .RST_LVL(1'b1)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_d <= 1'b1;
    else        scl_d <= clean_lines[0];
  end

  assign scl_rise = clean_lines[0] && !scl_d;
  assign scl_fall = !clean_lines[0] && scl_d;

  i2c_rx_engine u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (clean_lines[1]),
    .mode      (mode),
    .evt_clr   (evt_clr),
    .bit_cnt   (bit_cnt),
    .rx_buf    (rx_buf),
    .rx_split  (rx_split),
    .ack_stat  (ack_stat),
    .tx_flag   (tx_flag),
    .rx_flag   (rx_flag)
  );

  i2c_tx_engine #(.TX_DLY(TX_DLY)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .ack_low  (ack_low),
    .scl_fall (scl_fall),
    .bit_cnt  (bit_cnt),
    .clk_dly  (clk_dly),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe)
  );

  assign rx_data = rx_split ? {rx_buf[6:0], rx_buf[8]} : rx_buf[7:0];
endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_sel,
  input logic clk_dly,
  input logic scl_oe,
  input logic tx_flag,
  input logic rx_flag,
  input logic ack_stat,
  input logic rx_split,
  input logic scl_rise
);
  // R11
  mode_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({evt_sel, clk_dly}) |=> (!tx_flag && !rx_flag));

  // R3
  one_flag_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(tx_flag) && $rose(rx_flag)));

  // R2
  ack_on_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_stat) |-> $past(scl_rise));

  // R4
  split_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_split) |-> $past(evt_sel));

  // R10
  no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_dly |-> !scl_oe);
endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_sel  (evt_sel),
  .clk_dly  (clk_dly),
  .scl_oe   (scl_oe),
  .tx_flag  (tx_flag),
  .rx_flag  (rx_flag),
  .ack_stat (ack_stat),
  .rx_split (rx_split),
  .scl_rise (scl_rise)
);

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
  localparam int FILT = 4;
  localparam int DLY  = 3;
  localparam int PH   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, start_det = 1'b0;
  logic evt_sel = 1'b0, clk_dly = 1'b0, tx_load = 1'b0, ack_low = 1'b0, evt_clr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic scl_oe, sda_oe, rx_split, ack_stat, tx_flag, rx_flag;
  logic [8:0] rx_buf;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_byte_shifter #(.FILT_CYC(FILT), .TX_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .evt_sel(evt_sel), .clk_dly(clk_dly),
    .tx_load(tx_load), .tx_byte(tx_byte), .ack_low(ack_low), .evt_clr(evt_clr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_buf(rx_buf), .rx_data(rx_data),
    .rx_split(rx_split), .ack_stat(ack_stat), .tx_flag(tx_flag), .rx_flag(rx_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start_load(input logic [7:0] d, input logic ackl);
    start_det = 1'b1; tx_load = 1'b1; tx_byte = d; ack_low = ackl;
    cyc(1);
    start_det = 1'b0; tx_load = 1'b0;
  endtask

  // phase with optional 2-cycle SCL glitch in its middle (R1)
  task automatic phase(input bit glitch);
    cyc(PH / 2);
    if (glitch) begin
      scl_in = ~scl_in; cyc(2); scl_in = ~scl_in;
    end
    cyc(PH / 2);
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: pat = 8'h00; 1: pat = 8'hFF; 2: pat = 8'hA5; 3: pat = 8'h5A;
      4: pat = 8'h01; 5: pat = 8'h80; 6: pat = 8'h3C; default: pat = 8'hC3;
    endcase
  endfunction

  task automatic run_byte(input logic [7:0] d, input logic ack, input logic sel,
                          input logic dly, input bit glitch);
    logic bitv;
    logic [8:0] split_exp, norm_exp;
    split_exp = {d[0], 1'b0, d[7:1]};
    norm_exp  = {ack, d};
    evt_sel = sel; clk_dly = dly;
    cyc(3);
    // junk clocks before the start pulse (R2)
    for (int j = 0; j < 3; j++) begin
      scl_in = 1'b1; cyc(PH); scl_in = 1'b0; cyc(PH);
    end
    evt_clr = 1'b1; cyc(1); evt_clr = 1'b0;
    cyc(1);
    chk(!tx_flag && !rx_flag, "R11 clear", {tx_flag, rx_flag}, 0);
    pulse_start_load(d, ~ack);
    for (int k = 1; k <= 9; k++) begin
      bitv = (k <= 8) ? d[8-k] : ack;
      sda_in = bitv;
      phase(glitch && k == 4);
      chk(sda_oe == !bitv, "R8 sda bit", sda_oe, !bitv);
      scl_in = 1'b1;
      phase(glitch && k == 5);
      if (k == 9) begin
        chk(ack_stat == ack, "R2 ack_stat", ack_stat, ack);
        if (!sel) begin
          chk(rx_buf == norm_exp, "R3 buffer", rx_buf, norm_exp);
          chk(tx_flag == ack && rx_flag == !ack, "R3 flags", {tx_flag, rx_flag}, {ack, !ack});
          chk(rx_data == d && !rx_split, "R7 normal read", rx_data, d);
        end else if (!dly) begin
          chk(tx_flag, "R5 tx flag", tx_flag, 1);
          chk(rx_buf == split_exp, "R5 split kept", rx_buf, split_exp);
        end else begin
          chk(rx_buf == norm_exp && !rx_split, "R6 rewrite", rx_buf, norm_exp);
          chk(!tx_flag, "R6 tx not yet", tx_flag, 0);
        end
      end
      scl_in = 1'b0;
      phase(1'b0);
      if (k == 8) begin
        if (sel) begin
          chk(rx_buf == split_exp, "R4 split", rx_buf, split_exp);
          chk(rx_flag && !tx_flag && rx_split, "R4 rx flag", {tx_flag, rx_flag, rx_split}, 3'b011);
          chk(rx_data == d, "R7 split read", rx_data, d);
        end else begin
          chk(!rx_flag && !tx_flag, "R3 no early flag", {tx_flag, rx_flag}, 0);
        end
      end
      if (k == 9) begin
        if (sel && dly) chk(tx_flag, "R6 tx flag", tx_flag, 1);
        chk(scl_oe == dly, "R10 stretch", scl_oe, dly);
        chk(!sda_oe, "R8 release", sda_oe, 0);
      end
    end
  endtask

  task automatic latency(input logic dly, output int n);
    evt_sel = 1'b0; clk_dly = dly; scl_in = 1'b0; sda_in = 1'b1;
    cyc(3);
    pulse_start_load(8'h80, 1'b0);
    cyc(PH);
    scl_in = 1'b1; cyc(PH);
    scl_in = 1'b0;
    n = 0;
    while (!sda_oe && n < 100) begin
      cyc(1);
      n++;
    end
  endtask

  initial begin
    int l0, l1;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(!tx_flag && !rx_flag, "R11 reset flags", {tx_flag, rx_flag}, 0);
    chk(rx_buf == 9'h0 && !rx_split, "R7 reset buffer", rx_buf, 0);
    chk(!scl_oe && !sda_oe, "R10 reset oe", {scl_oe, sda_oe}, 0);
    clk_dly = 1'b1; cyc(1);
    chk(scl_oe, "R10 hold from reset", scl_oe, 1);
    scl_in = 1'b0; cyc(PH);

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        for (int a = 0; a < 2; a++)
          run_byte(pat(i), a[0], m[1], m[0], 1'b0);

    // short glitches are filtered (R1)
    run_byte(8'h96, 1'b0, 1'b0, 1'b0, 1'b1);
    run_byte(8'h69, 1'b1, 1'b1, 1'b1, 1'b1);

    // mode change clears set flags (R11)
    run_byte(8'h42, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(tx_flag && rx_flag, "R11 flags set", {tx_flag, rx_flag}, 3);
    clk_dly = 1'b1; cyc(2);
    chk(!tx_flag && !rx_flag, "R11 mode change", {tx_flag, rx_flag}, 0);

    // output delay (R9)
    latency(1'b0, l0);
    latency(1'b1, l1);
    chk(l1 - l0 == DLY, "R9 delay", l1 - l0, DLY);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule